// File: doc/BRIEF.md
# Chip-Select Bank Timing Controller

This block sits between a processor-side request port and a set of asynchronous memory or peripheral devices. It holds a small number of programmable banks, each described by a base word and an option word. When a request arrives, the upper address bits are compared with every bank's base under that bank's mask. The lowest-numbered bank that matches is selected, and the block plays out a chip-select, output-enable and write-enable sequence whose length comes from the selected bank's option word. It then returns an acknowledge. A request that hits no bank, or that writes to a write-protected bank, is answered with an error and drives no strobes.

Per bank, software can choose the wait-state count, doubled wait states for slow parts, one setup cycle between address and chip-select, early release of chip-select and write-enable, and one idle turnaround cycle after reads. The software can also choose whether the internal timer ends the access or only the external acknowledge input does. Only one access is in flight at a time. A new start is taken in the idle state or in the cycle that carries the acknowledge, so accesses can run back to back.

Top module: `csbank_ctrl`

## Requirements
- R1: A bank matches when its valid flag (base bit 0) is 1, its machine-select field (base bits 7:5) is 000, and address bits 31:15 XOR the base field (base bits 31:15) are zero wherever the mask (option bits 31:15) is 1. If several banks match, the lowest index drives its chip-select bit. Any other machine-select value makes the bank never match.
- R2: A request that matches no bank drives no chip-select, output-enable or write-enable. It sees acknowledge and error high together in the first cycle after the start is sampled.
- R3: With the write-protect bit (base bit 8) set, reads complete normally. A write is answered as in R2, with write-enable never asserted.
- R4: With setup 00 and relaxed timing off, the access begins in the first cycle after the start edge: chip-select and the address output assert together. The acknowledge comes W+1 cycles after the start edge, where W is the cycle-length field (option bits 7:4).
- R5: With the relaxed bit (option bit 2) set, W is twice the cycle-length field.
- R6: With a non-zero setup field (option bits 10:9), the address output leads chip-select by one cycle, and the acknowledge moves one cycle later.
- R7: Output-enable is high in the chip-select cycles of a read, including the final cycle. Write-enable is high only while chip-select is high during a write. The two are never high together.
- R8: With the early-negation bit (option bit 11) set and W above zero, chip-select and write-enable are low in the internally timed final cycle.
- R9: With the external-only bit (option bit 3) at 0, an external acknowledge in any access cycle ends the access in that same cycle. With it at 1, only the external acknowledge ends the access.
- R10: When a read from a bank whose extended-hold bit (option bit 1) is set is followed at once by an access to a different bank, one cycle with no strobes comes before the new access. Accesses to the same bank, and accesses that follow a write, get no such cycle.
- R11: A start is ignored while an access is in progress, except in the cycle that carries the acknowledge, where it is accepted.
- R12: Bank words are written through the register port: an index plus a select, 0 for the base word and 1 for the option word. After reset every bank is invalid and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Bank index for the write |
| reg_is_opt | input | 1 | 0 writes the base word, 1 writes the option word |
| reg_wdata | input | 32 | Register write data |
| req_start | input | 1 | Request start |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_addr | input | ADDR_W | Request address |
| req_ack | output | 1 | Transfer acknowledge |
| req_err | output | 1 | Error, valid with req_ack |
| ext_ack | input | 1 | External early acknowledge |
| mem_cs | output | NBANK | Per-bank chip-select, active high |
| mem_oe | output | 1 | Output-enable, active high |
| mem_we | output | 1 | Write-enable, active high |
| mem_addr | output | ADDR_W | Latched address, zero outside an access |

## Verification
The hardest case to reach is the turnaround cycle. It appears only when a new start lands exactly in the acknowledge cycle of a read from an extended-hold bank and targets another bank. The stimulus therefore raises the second start in the cycle whose index equals the first access's expected length, and it compares the second latency with and without a bank change. The busy-time start filter is covered by holding the start line high across three whole accesses and counting the acknowledges. The external-acknowledge race is covered by pulsing that input before the internal timer expires.

// File: rtl/csbank_pkg.sv
// Shared constants, field positions and types for the chip-select bank
// controller. Assumes 32-bit bank words with bit 31 as the most significant.
package csbank_pkg;

    localparam int REG_W   = 32;
    localparam int MATCH_W = 17;
    localparam int CYC_W   = 4;
    localparam int WAIT_W  = CYC_W + 1;
    localparam int CNT_W   = WAIT_W + 1;

    // Base word field positions
    localparam int B_ADDR_HI = 31;
    localparam int B_WP      = 8;
    localparam int B_MS_HI   = 7;
    localparam int B_MS_LO   = 5;
    localparam int B_VALID   = 0;

    // Option word field positions
    localparam int O_MASK_HI = 31;
    localparam int O_NEG     = 11;
    localparam int O_SU_HI   = 10;
    localparam int O_SU_LO   = 9;
    localparam int O_CYC_HI  = 7;
    localparam int O_CYC_LO  = 4;
    localparam int O_XONLY   = 3;
    localparam int O_RELAX   = 2;
    localparam int O_EHOLD   = 1;

    // Decoded per-bank configuration; only the fields the block acts on
    typedef struct packed {
        logic                 valid;
        logic [MATCH_W-1:0]   base;
        logic                 wprot;
        logic [2:0]           msel;
        logic [MATCH_W-1:0]   mask;
        logic                 early_neg;
        logic [1:0]           setup;
        logic [CYC_W-1:0]     cycles;
        logic                 ext_only;
        logic                 relax;
        logic                 rd_hold;
    } bank_cfg_t;

    // Timing snapshot taken when an access is accepted
    typedef struct packed {
        logic                 setup;
        logic [WAIT_W-1:0]    waits;
        logic                 early_neg;
        logic                 ext_only;
        logic                 rd_hold;
    } bank_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_ACC  = 2'd2,
        ST_ERR  = 2'd3
    } seq_state_e;

    // Convert a bank configuration into the timing the sequencer uses
    function automatic bank_timing_t to_timing(input bank_cfg_t c);
        bank_timing_t t;
        t.setup     = (c.setup != 2'b00);
        t.waits     = c.relax ? {c.cycles, 1'b0} : {1'b0, c.cycles};
        t.early_neg = c.early_neg;
        t.ext_only  = c.ext_only;
        t.rd_hold   = c.rd_hold;
        return t;
    endfunction

endpackage

// File: rtl/csbank_regfile.sv
// Bank register storage. Keeps only the fields the controller acts on,
// split out of each 32-bit write. Assumes one write per cycle; a base write
// and an option write of the same bank need two cycles.
module csbank_regfile
    import csbank_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_opt,
    input  logic [REG_W-1:0]        wr_data,
    output bank_cfg_t [NBANK-1:0]   cfg
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Base-word fields of one bank: cleared on reset, loaded on a base write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[b].valid <= 1'b0;
                cfg[b].base  <= '0;
                cfg[b].wprot <= 1'b0;
                cfg[b].msel  <= '0;
            end else if (wr_en && !wr_opt && wr_idx == IDX_W'(b)) begin
                cfg[b].valid <= wr_data[B_VALID];
                cfg[b].base  <= wr_data[B_ADDR_HI -: MATCH_W];
                cfg[b].wprot <= wr_data[B_WP];
                cfg[b].msel  <= wr_data[B_MS_HI:B_MS_LO];
            end
        end

        // Option-word fields of one bank: cleared on reset, loaded on an option write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[b].mask      <= '0;
                cfg[b].early_neg <= 1'b0;
                cfg[b].setup     <= '0;
                cfg[b].cycles    <= '0;
                cfg[b].ext_only  <= 1'b0;
                cfg[b].relax     <= 1'b0;
                cfg[b].rd_hold   <= 1'b0;
            end else if (wr_en && wr_opt && wr_idx == IDX_W'(b)) begin
                cfg[b].mask      <= wr_data[O_MASK_HI -: MATCH_W];
                cfg[b].early_neg <= wr_data[O_NEG];
                cfg[b].setup     <= wr_data[O_SU_HI:O_SU_LO];
                cfg[b].cycles    <= wr_data[O_CYC_HI:O_CYC_LO];
                cfg[b].ext_only  <= wr_data[O_XONLY];
                cfg[b].relax     <= wr_data[O_RELAX];
                cfg[b].rd_hold   <= wr_data[O_EHOLD];
            end
        end
    end

endmodule

// File: rtl/csbank_match.sv
// Address decoder: compares the upper address bits against every bank and
// picks the lowest-numbered hit. Purely combinational. Assumes ADDR_W >= 17.
module csbank_match
    import csbank_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]       addr,
    input  bank_cfg_t [NBANK-1:0]   cfg,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx,
    output logic                    wprot,
    output bank_timing_t            timing
);

    logic [MATCH_W-1:0] addr_hi;
    logic [NBANK-1:0]   hit_vec;

    assign addr_hi = addr[ADDR_W-1 -: MATCH_W];

    for (genvar b = 0; b < NBANK; b++) begin : g_cmp
        // Per-bank compare: valid, this machine selected, masked bits equal
        always_comb begin
            hit_vec[b] = cfg[b].valid && (cfg[b].msel == 3'b000) &&
                         (((addr_hi ^ cfg[b].base) & cfg[b].mask) == '0);
        end
    end

    // Priority pick: scanning downward leaves the lowest hit index
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int b = NBANK - 1; b >= 0; b--) begin
            if (hit_vec[b]) begin
                hit = 1'b1;
                idx = IDX_W'(b);
            end
        end
    end

    // Attributes of the selected bank
    always_comb begin
        wprot  = cfg[idx].wprot;
        timing = to_timing(cfg[idx]);
    end

endmodule

// File: rtl/csbank_seq.sv
// Access sequencer: accepts a decoded request, optionally inserts a
// turnaround cycle, then times the strobes and the acknowledge. Assumes the
// decode inputs are valid in the cycle req_start is high.
module csbank_seq
    import csbank_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                write,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                ext_ack,
    input  logic                hit,
    input  logic [IDX_W-1:0]    idx,
    input  logic                wprot,
    input  bank_timing_t        timing,
    output logic [NBANK-1:0]    mem_cs,
    output logic                mem_oe,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                ack,
    output logic                err
);

    seq_state_e         state, state_nx;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   final_k;
    logic               cur_wr;
    logic [IDX_W-1:0]   cur_bank;
    logic [ADDR_W-1:0]  cur_addr;
    bank_timing_t       cur_t;

    logic               in_acc;
    logic               past_setup;
    logic               int_end;
    logic               cs_on;
    logic               accept;
    logic               reject;
    logic               need_turn;

    // Final cycle index of an internally timed access
    always_comb begin
        final_k = CNT_W'(cur_t.setup) + CNT_W'(cur_t.waits);
    end

    // Cycle qualifiers for the access phase
    always_comb begin
        in_acc     = (state == ST_ACC);
        past_setup = (cnt >= CNT_W'(cur_t.setup));
        int_end    = in_acc && !cur_t.ext_only && (cnt == final_k);
        cs_on      = in_acc && past_setup &&
                     !(cur_t.early_neg && (cur_t.waits != '0) && int_end);
    end

    // Memory-side strobes and processor-side acknowledge
    always_comb begin
        mem_cs   = cs_on ? (NBANK'(1) << cur_bank) : '0;
        mem_oe   = in_acc && past_setup && !cur_wr;
        mem_we   = cs_on && cur_wr;
        mem_addr = in_acc ? cur_addr : '0;
        err      = (state == ST_ERR);
        ack      = err || (in_acc && (int_end || ext_ack));
    end

    // Acceptance and routing of a new request
    always_comb begin
        accept    = start && ((state == ST_IDLE) || ack);
        reject    = !hit || (write && wprot);
        need_turn = in_acc && !cur_wr && cur_t.rd_hold && (idx != cur_bank);
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        if (accept) begin
            if (reject)         state_nx = ST_ERR;
            else if (need_turn) state_nx = ST_TURN;
            else                state_nx = ST_ACC;
        end else if (ack) begin
            state_nx = ST_IDLE;
        end else if (state == ST_TURN) begin
            state_nx = ST_ACC;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Access cycle counter: restarts on entry to the access phase, saturates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (accept || state == ST_TURN) begin
            cnt <= '0;
        end else if (in_acc && cnt != '1) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Request snapshot taken on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr   <= 1'b0;
            cur_bank <= '0;
            cur_addr <= '0;
            cur_t    <= '0;
        end else if (accept) begin
            cur_wr   <= write;
            cur_bank <= idx;
            cur_addr <= addr;
            cur_t    <= timing;
        end
    end

endmodule

// File: rtl/csbank_ctrl.sv
// Top of the chip-select bank controller: register storage, address decode
// and access sequencer. Assumes a single clock domain and that ext_ack is
// synchronous to clk.
module csbank_ctrl
    import csbank_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic                reg_is_opt,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                req_start,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ack,
    output logic                req_err,
    input  logic                ext_ack,
    output logic [NBANK-1:0]    mem_cs,
    output logic                mem_oe,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr
);

    bank_cfg_t [NBANK-1:0] cfg;
    logic                  dec_hit;
    logic [IDX_W-1:0]      dec_idx;
    logic                  dec_wprot;
    bank_timing_t          dec_timing;

    csbank_regfile #(.NBANK(NBANK), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_idx  (reg_idx),
        .wr_opt  (reg_is_opt),
        .wr_data (reg_wdata),
        .cfg     (cfg)
    );

    csbank_match #(.NBANK(NBANK), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_match (
        .addr    (req_addr),
        .cfg     (cfg),
        .hit     (dec_hit),
        .idx     (dec_idx),
        .wprot   (dec_wprot),
        .timing  (dec_timing)
    );

    csbank_seq #(.NBANK(NBANK), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_start),
        .write    (req_write),
        .addr     (req_addr),
        .ext_ack  (ext_ack),
        .hit      (dec_hit),
        .idx      (dec_idx),
        .wprot    (dec_wprot),
        .timing   (dec_timing),
        .mem_cs   (mem_cs),
        .mem_oe   (mem_oe),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .ack      (req_ack),
        .err      (req_err)
    );

endmodule

// File: rtl/csbank_chk.sv
// Port-level protocol checks for the chip-select bank controller, bound to
// every instance of the top module.
module csbank_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] mem_cs,
    input logic             mem_oe,
    input logic             mem_we,
    input logic             req_ack,
    input logic             req_err
);

    // R7: output-enable and write-enable never overlap
    a_r7_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_oe && mem_we));

    // R7: write-enable only inside a chip-select window
    a_r7_we_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_cs != '0));

    // R1: at most one bank selected at any time
    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));

    // R2: an error is always delivered with the acknowledge
    a_r2_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ack);

    // R2: an error cycle drives no memory strobe
    a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (mem_cs == '0 && !mem_oe && !mem_we));

endmodule

bind csbank_ctrl csbank_chk #(.NBANK(NBANK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_cs  (mem_cs),
    .mem_oe  (mem_oe),
    .mem_we  (mem_we),
    .req_ack (req_ack),
    .req_err (req_err)
);

// File: tb/sim_csbank_ctrl.sv
`timescale 1ns/1ps
module sim_csbank_ctrl;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic        reg_is_opt = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        ext_ack = 1'b0;
    logic        req_ack, req_err, mem_oe, mem_we;
    logic [3:0]  mem_cs;
    logic [31:0] mem_addr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    csbank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_is_opt(reg_is_opt), .reg_wdata(reg_wdata), .req_start(req_start),
        .req_write(req_write), .req_addr(req_addr), .req_ack(req_ack),
        .req_err(req_err), .ext_ack(ext_ack), .mem_cs(mem_cs), .mem_oe(mem_oe),
        .mem_we(mem_we), .mem_addr(mem_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_base [NB];
    logic [31:0] m_opt  [NB];
    int m_ph = 0;          // 0 idle, 1 turnaround, 2 access, 3 error
    int m_k = 0, m_bk = 0, m_s = 0, m_w = 0;
    bit m_wr = 0, m_neg = 0, m_xo = 0, m_eh = 0;
    logic [31:0] m_ad = '0;

    function automatic int m_find(input logic [31:0] a);
        for (int b = 0; b < NB; b++)
            if (m_base[b][0] && m_base[b][7:5] == 3'b000 &&
                (((a[31:15] ^ m_base[b][31:15]) & m_opt[b][31:15]) == 17'd0))
                return b;
        return -1;
    endfunction

    function automatic bit m_iend();
        return m_ph == 2 && !m_xo && m_k == m_s + m_w;
    endfunction

    function automatic bit m_ack();
        return m_ph == 3 || (m_ph == 2 && (m_iend() || ext_ack));
    endfunction

    function automatic bit m_cson();
        return m_ph == 2 && m_k >= m_s && !(m_neg && m_w > 0 && m_iend());
    endfunction

    always @(posedge clk) begin
        bit a_now, acc, turn;
        int b;
        if (!rst_n) begin
            m_ph = 0; m_k = 0;
            for (int i = 0; i < NB; i++) begin m_base[i] = '0; m_opt[i] = '0; end
        end else begin
            a_now = m_ack();
            acc = req_start && (m_ph == 0 || a_now);
            if (acc) begin
                b = m_find(req_addr);
                if (b < 0) m_ph = 3;
                else if (req_write && m_base[b][8]) m_ph = 3;
                else begin
                    turn = (m_ph == 2 && !m_wr && m_eh && b != m_bk);
                    m_bk = b; m_wr = req_write; m_ad = req_addr;
                    m_s = (m_opt[b][10:9] != 2'b00) ? 1 : 0;
                    m_w = int'(m_opt[b][7:4]) * (m_opt[b][2] ? 2 : 1);
                    m_neg = m_opt[b][11]; m_xo = m_opt[b][3]; m_eh = m_opt[b][1];
                    m_k = 0;
                    m_ph = turn ? 1 : 2;
                end
            end else if (a_now) m_ph = 0;
            else if (m_ph == 1) begin m_ph = 2; m_k = 0; end
            else if (m_ph == 2) m_k++;
            if (reg_we) begin
                if (reg_is_opt) m_opt[reg_idx] = reg_wdata;
                else            m_base[reg_idx] = reg_wdata;
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        logic [3:0] e_cs;
        logic [31:0] e_ad;
        if (rst_n) begin
            e_cs = m_cson() ? (4'b0001 << m_bk) : 4'b0000;
            e_ad = (m_ph == 2) ? m_ad : 32'd0;
            chk(req_ack == m_ack() && req_err == (m_ph == 3), "R2 R4 R9 cycle ack/err",
                {30'd0, req_ack, req_err}, {30'd0, m_ack(), m_ph == 3});
            chk(mem_cs == e_cs, "R1 R6 R8 cycle cs", {28'd0, mem_cs}, {28'd0, e_cs});
            chk(mem_oe == (m_ph == 2 && !m_wr && m_k >= m_s) && mem_we == (m_cson() && m_wr),
                "R7 cycle oe/we", {30'd0, mem_oe, mem_we},
                {30'd0, m_ph == 2 && !m_wr && m_k >= m_s, m_cson() && m_wr});
            chk(mem_addr == e_ad, "R6 cycle addr", mem_addr, e_ad);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mkb(input logic [31:0] a, input bit wp, input logic [2:0] ms, input bit v);
        return {a[31:15], 6'd0, wp, ms, 4'd0, v};
    endfunction

    function automatic logic [31:0] mko(input logic [16:0] msk, input bit neg, input logic [1:0] su,
                                        input logic [3:0] cyc, input bit xo, input bit rlx, input bit eh);
        return {msk, 3'd0, neg, su, 1'b0, cyc, xo, rlx, eh, 1'b0};
    endfunction

    task automatic wr_reg(input int i, input bit opt, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_idx = 2'(i); reg_is_opt = opt; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] a, input bit w, input int ext_at,
                          output int n, output bit e, output logic [3:0] cs_or,
                          output bit oe_s, output bit we_s, output int cs_cnt, output int we_cnt);
        @(posedge clk); #1;
        req_start = 1'b1; req_addr = a; req_write = w; ext_ack = 1'b0;
        n = 0; e = 0; cs_or = '0; oe_s = 0; we_s = 0; cs_cnt = 0; we_cnt = 0;
        for (int i = 1; i <= 80; i++) begin
            @(posedge clk); #1;
            req_start = 1'b0; ext_ack = (i == ext_at);
            @(negedge clk);
            cs_or |= mem_cs; oe_s |= mem_oe; we_s |= mem_we;
            if (mem_cs != 0) cs_cnt++;
            if (mem_we) we_cnt++;
            if (req_ack) begin n = i; e = req_err; break; end
        end
        @(posedge clk); #1;
        ext_ack = 1'b0;
    endtask

    task automatic do_b2b(input logic [31:0] a1, input bit w1, input int n1,
                          input logic [31:0] a2, input bit w2, output int n2);
        @(posedge clk); #1;
        req_start = 1'b1; req_addr = a1; req_write = w1;
        for (int i = 1; i <= n1; i++) begin
            @(posedge clk); #1;
            if (i == n1) begin req_start = 1'b1; req_addr = a2; req_write = w2; end
            else req_start = 1'b0;
            @(negedge clk);
        end
        n2 = 0;
        for (int m = 1; m <= 80; m++) begin
            @(posedge clk); #1;
            req_start = 1'b0;
            @(negedge clk);
            if (req_ack) begin n2 = m; break; end
        end
        @(posedge clk); #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(4 * 50000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, cc, wc, acks;
        bit e, oe_s, we_s;
        logic [3:0] cso;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ack && !req_err && mem_cs == 0 && !mem_oe && !mem_we && mem_addr == 0,
            "R12 reset outputs", {req_ack, req_err, mem_oe, mem_we, mem_cs}, 0);

        // R12: nothing valid after reset
        do_req(32'hFF80_0000, 0, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(n == 1 && e, "R12 R2 unprogrammed bank errors", n, 1);

        wr_reg(0, 1, mko(17'h1FF00, 0, 2'b00, 4'd3, 0, 0, 1));
        wr_reg(0, 0, mkb(32'hFF80_0000, 0, 3'b000, 1));
        wr_reg(1, 1, mko(17'h1FFFF, 0, 2'b00, 4'd2, 0, 1, 0));
        wr_reg(1, 0, mkb(32'h0400_0000, 1, 3'b000, 1));
        wr_reg(2, 1, mko(17'h1F000, 0, 2'b01, 4'd1, 0, 0, 0));
        wr_reg(2, 0, mkb(32'h0400_0000, 0, 3'b000, 1));
        wr_reg(3, 1, mko(17'h1FFFF, 1, 2'b00, 4'd2, 0, 0, 0));
        wr_reg(3, 0, mkb(32'h2000_0000, 0, 3'b000, 1));

        do_req(32'hFF80_0010, 0, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(n == 4 && !e, "R4 read latency", n, 4);
        chk(cso == 4'b0001 && oe_s && !we_s, "R7 read strobes", {cso, oe_s, we_s}, {4'b0001, 2'b10});

        do_req(32'hFFF0_1234, 1, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(cso == 4'b0001 && n == 4, "R1 masked address matches", cso, 4'b0001);
        chk(we_s && !oe_s, "R7 write strobes", {oe_s, we_s}, 2'b01);

        do_req(32'h0400_0000, 0, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(cso == 4'b0010, "R1 lowest bank wins", cso, 4'b0010);
        chk(n == 5, "R5 relaxed doubles waits", n, 5);
        chk(!e, "R3 read of protected bank allowed", e, 0);

        do_req(32'h0400_0000, 1, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(e && n == 1 && !we_s && cso == 0, "R3 protected write errors", {e, we_s, cso}, {1'b1, 5'd0});

        do_req(32'h0410_0000, 0, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(n == 3 && cc == 2 && cso == 4'b0100, "R6 setup cycle", {n, cc}, {3, 2});

        do_req(32'h2000_0000, 1, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(n == 3 && cc == 2 && wc == 2, "R8 early negation", {cc, wc}, {2, 2});

        do_req(32'h8000_0000, 0, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(e && n == 1 && cso == 0 && !oe_s, "R2 miss errors quietly", {e, cso}, {1'b1, 4'd0});

        do_req(32'hFF80_0000, 0, 2, n, e, cso, oe_s, we_s, cc, wc);
        chk(n == 2 && !e, "R9 external ack ends early", n, 2);

        wr_reg(3, 1, mko(17'h1FFFF, 1, 2'b00, 4'd2, 1, 0, 0));
        do_req(32'h2000_0000, 0, 7, n, e, cso, oe_s, we_s, cc, wc);
        chk(n == 7 && !e, "R9 external-only waits for ext ack", n, 7);

        wr_reg(3, 0, mkb(32'h2000_0000, 0, 3'b010, 1));
        do_req(32'h2000_0000, 0, 0, n, e, cso, oe_s, we_s, cc, wc);
        chk(e && n == 1, "R1 other machine select ignored", e, 1);

        do_b2b(32'hFF80_0000, 0, 4, 32'h0410_0000, 0, n);
        chk(n == 4, "R10 turnaround after hold read", n, 4);
        do_b2b(32'hFF80_0000, 0, 4, 32'hFF80_0040, 0, n);
        chk(n == 4, "R10 same bank no turnaround", n, 4);
        do_b2b(32'hFF80_0000, 1, 4, 32'h0410_0000, 0, n);
        chk(n == 3, "R10 write needs no turnaround", n, 3);

        // R11: start held high across several accesses
        @(posedge clk); #1;
        req_start = 1'b1; req_addr = 32'hFF80_0000; req_write = 1'b0;
        acks = 0;
        for (int i = 1; i <= 12; i++) begin
            @(posedge clk); #1;
            @(negedge clk);
            if (req_ack) acks++;
        end
        @(posedge clk); #1;
        req_start = 1'b0;
        repeat (10) @(posedge clk);
        chk(acks == 3, "R11 busy starts ignored", acks, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule